// File: doc/BRIEF.md
# Strobed I/O Port Sequencer

This block runs one exchange on a four-pin open-drain port that connects to external sensors and actuators. Each exchange is paired with an active-low strobe. When the protocol logic asks for an exchange, the block does four things. It captures a per-pin mode word and an output nibble. It pulls the strobe low for a fixed number of clock cycles. It drives the pins that carry output data. It then samples the pins that carry input data at a fixed cycle, counted from the strobe's falling edge.

Each pin has one of three modes:

- Output: the pin drives its bit until the next exchange begins.
- Output/input: the pin drives its bit only across the strobe's low phase and a short hold after it, then releases the line so that it can be read.
- Input: the pin is never driven.

All times are counted in cycles of the 5.333333 MHz port clock. The default strobe width is 34 cycles (about 6.4 µs). The hold after the rising edge is 3 cycles (at least 0.4 µs and under 1 µs). Sampling takes place 62 cycles (about 11.6 µs) after the falling edge, which lies inside the 10.5 to 12.5 µs input window.

Top module: `strobe_port_seq`

## Requirements
- R1: During and directly after reset, the outputs are as follows: `strobeN` is 1, every `pinOeN` bit is 1 (released), `inData` is 0 and `done` is 0.
- R2: A `start` that the block accepts on a clock edge pulls `strobeN` low from that edge onward for exactly 34 cycles. Counting the first low cycle as cycle 0, the strobe is high again in cycle 34.
- R3: The port is open-drain. A driven pin whose bit is 0 has `pinOeN` = 0. A driven pin whose bit is 1, and any undriven pin, has `pinOeN` = 1. Driven pins show the captured `outData` from cycle 0 onward.
- R4: A pin in mode 2'b00 (output) keeps its drive after the exchange ends. The drive changes only in cycle 0 of the next exchange.
- R5: A pin in mode 2'b01 (output/input) keeps its drive until the end of cycle 36, which is 3 cycles after the strobe rises. The pin is released from cycle 37 onward.
- R6: A pin in mode 2'b10 or 2'b11 (input) is never driven, so its `pinOeN` stays 1.
- R7: At the clock edge that ends cycle 61, each `inData` bit captures its pin as follows: `pinIn` for pins in mode 01, 10 or 11, and 0 for pins in mode 00. The new value is visible from cycle 62 and holds until the next sample.
- R8: `done` is 1 for exactly one cycle, cycle 62, and is 0 at all other times.
- R9: A `start` that arrives while an exchange is in progress (cycles 0 to 61) is ignored. It does not restart the strobe or add a second `done`.
- R10: The per-pin modes in `cfg` (pin i in bits [2i+1:2i]) and the `outData` bits are captured only when a `start` is accepted. Changes to them during an exchange have no effect.
- R11: A `start` in the `done` cycle is accepted, and its strobe goes low in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request for one exchange |
| outData | input | 4 | Output nibble, one bit per pin |
| cfg | input | 8 | Mode per pin, two bits each: 00 output, 01 output/input, 10 or 11 input |
| pinOeN | output | 4 | Open-drain pull-down enables, active low |
| pinIn | input | 4 | Pin levels as read back from the pads |
| strobeN | output | 1 | Active-low strobe |
| inData | output | 4 | Input nibble sampled in the latest exchange |
| done | output | 1 | One-cycle pulse when `inData` is updated |

## Verification
The hardest situations to reach from the ports are the cycles where a timing rule meets a state change. These are a `start` that lands exactly in the `done` cycle, and a `start` together with a new mode word that arrive in the middle of an exchange. The stimulus reaches them by counting cycles from the strobe's falling edge. It raises `start` in cycle 62 for the back-to-back case, and in cycle 10 with altered `cfg` and `outData` for the busy case. It then checks the pin enables on both sides of the release cycle (cycles 36 and 37) and the strobe edges at cycles 33 and 34.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;

  typedef enum logic [1:0] {
    MODE_OUT    = 2'b00,
    MODE_OUTIN  = 2'b01,
    MODE_IN     = 2'b10,
    MODE_IN_ALT = 2'b11
  } pinMode_t;

  // Strobes sent from the sequencer to the pin datapath
  typedef struct packed {
    logic launch;   // capture cfg/outData, start driving
    logic relOi;    // release output/input pins at this edge
    logic sample;   // capture pin levels at this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/strobe_port_ctrl.sv
module strobe_port_ctrl
  import strobe_port_pkg::*;
#(
  parameter int LOW_CYC    = 34,
  parameter int HOLD_CYC   = 3,
  parameter int SAMPLE_CYC = 62
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t ctl,
  output logic         strobeN,
  output logic         done
);

  localparam int CW = $clog2(SAMPLE_CYC + 1);
  localparam logic [CW-1:0] LOW_LAST    = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] REL_LAST    = CW'(LOW_CYC + HOLD_CYC - 1);
  localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_TAIL} seqState_t;

  seqState_t       state;
  logic [CW-1:0]   cnt;

  always_comb begin
    ctl.launch = (state == ST_IDLE) && start;
    ctl.relOi  = (state == ST_TAIL) && (cnt == REL_LAST);
    ctl.sample = (state == ST_TAIL) && (cnt == SAMPLE_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      strobeN <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= ctl.sample;
      unique case (state)
        ST_IDLE: begin
          if (ctl.launch) begin
            state   <= ST_LOW;
            cnt     <= '0;
            strobeN <= 1'b0;
          end
        end
        ST_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == LOW_LAST) begin
            strobeN <= 1'b1;
            state   <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          cnt <= cnt + 1'b1;
          if (cnt == SAMPLE_LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strobe_port_dpath.sv
module strobe_port_dpath
  import strobe_port_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       ctl,
  input  logic [2*NPINS-1:0] cfg,
  input  logic [NPINS-1:0]   outData,
  input  logic [NPINS-1:0]   pinIn,
  output logic [NPINS-1:0]   pinOeN,
  output logic [NPINS-1:0]   inData
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pinMode_t cfgMode;
    pinMode_t modeQ;
    logic     driveQ;
    logic     dataQ;
    logic     inQ;

    assign cfgMode = pinMode_t'(cfg[2*i +: 2]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ  <= MODE_IN;
        driveQ <= 1'b0;
        dataQ  <= 1'b1;
        inQ    <= 1'b0;
      end else begin
        if (ctl.launch) begin
          modeQ  <= cfgMode;
          dataQ  <= outData[i];
          driveQ <= (cfgMode == MODE_OUT) || (cfgMode == MODE_OUTIN);
        end else if (ctl.relOi && (modeQ == MODE_OUTIN)) begin
          driveQ <= 1'b0;
        end
        if (ctl.sample) inQ <= (modeQ == MODE_OUT) ? 1'b0 : pinIn[i];
      end
    end

    assign pinOeN[i] = ~(driveQ & ~dataQ);
    assign inData[i] = inQ;
  end

endmodule

// File: rtl/strobe_port_seq.sv
module strobe_port_seq
  import strobe_port_pkg::*;
#(
  parameter int NPINS      = 4,
  parameter int LOW_CYC    = 34,
  parameter int HOLD_CYC   = 3,
  parameter int SAMPLE_CYC = 62
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NPINS-1:0]   outData,
  input  logic [2*NPINS-1:0] cfg,
  output logic [NPINS-1:0]   pinOeN,
  input  logic [NPINS-1:0]   pinIn,
  output logic               strobeN,
  output logic [NPINS-1:0]   inData,
  output logic               done
);

  ctrlStrobes_t ctl;

  strobe_port_ctrl #(
    .LOW_CYC   (LOW_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .SAMPLE_CYC(SAMPLE_CYC)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .ctl    (ctl),
    .strobeN(strobeN),
    .done   (done)
  );

  strobe_port_dpath #(
    .NPINS(NPINS)
  ) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .cfg    (cfg),
    .outData(outData),
    .pinIn  (pinIn),
    .pinOeN (pinOeN),
    .inData (inData)
  );

endmodule

// File: rtl/strobe_port_seq_chk.sv
module strobe_port_seq_chk #(
  parameter int NPINS      = 4,
  parameter int LOW_CYC    = 34,
  parameter int HOLD_CYC   = 3,
  parameter int SAMPLE_CYC = 62
) (
  input logic             clk,
  input logic             rstN,
  input logic             strobeN,
  input logic             done,
  input logic [NPINS-1:0] pinOeN,
  input logic [NPINS-1:0] inData
);

  localparam int CW = $clog2(SAMPLE_CYC + 2);
  localparam logic [CW-1:0] LOW_W   = CW'(LOW_CYC);
  localparam logic [CW-1:0] REL_AT  = CW'(LOW_CYC + HOLD_CYC);
  localparam logic [CW-1:0] SAT_MAX = '1;

  logic [CW-1:0] lowCnt;
  logic [CW-1:0] sinceFall;
  logic          prevStrobe;
  logic          fallAllowed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt      <= '0;
      sinceFall   <= '0;
      prevStrobe  <= 1'b1;
      fallAllowed <= 1'b1;
    end else begin
      prevStrobe <= strobeN;
      if (strobeN) lowCnt <= '0;
      else if (lowCnt != SAT_MAX) lowCnt <= lowCnt + 1'b1;
      if (prevStrobe && !strobeN) sinceFall <= CW'(1);
      else if (sinceFall != SAT_MAX) sinceFall <= sinceFall + 1'b1;
      if (done) fallAllowed <= 1'b1;
      else if (prevStrobe && !strobeN) fallAllowed <= 1'b0;
    end
  end

  // R2: strobe low phase has the configured width
  a_r2_low_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeN) |-> (lowCnt == LOW_W));

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done occurs with the strobe released
  a_r8_done_strobe_high: assert property (@(posedge clk) disable iff (!rstN)
    done |-> strobeN);

  // R9: a new falling edge only after the previous exchange finished
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeN) |-> fallAllowed);

  // R7: input nibble changes only together with done
  a_r7_in_stable: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(inData));

  // R4 R5: pin drive changes only at the falling edge or the release cycle
  a_r5_drive_edges: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinOeN) |-> ($fell(strobeN) || (sinceFall == REL_AT)));

endmodule

bind strobe_port_seq strobe_port_seq_chk #(
  .NPINS     (NPINS),
  .LOW_CYC   (LOW_CYC),
  .HOLD_CYC  (HOLD_CYC),
  .SAMPLE_CYC(SAMPLE_CYC)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .strobeN(strobeN),
  .done   (done),
  .pinOeN (pinOeN),
  .inData (inData)
);

// File: tb/strobe_port_seq_test.sv
module strobe_port_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] outData = 4'h0;
  logic [7:0] cfg = 8'h00;
  logic [3:0] pinIn = 4'h0;
  logic [3:0] pinOeN;
  logic       strobeN;
  logic [3:0] inData;
  logic       done;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  strobe_port_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .outData(outData), .cfg(cfg),
    .pinOeN(pinOeN), .pinIn(pinIn), .strobeN(strobeN), .inData(inData), .done(done)
  );

  // {cfg, outData, pinIn}
  localparam logic [15:0] VEC [6] = '{
    {8'b00_00_00_00, 4'b1010, 4'b1111},
    {8'b01_01_01_01, 4'b0000, 4'b0110},
    {8'b10_10_10_10, 4'b0000, 4'b1001},
    {8'b11_01_00_10, 4'b0000, 4'b0101},
    {8'b00_01_10_01, 4'b0101, 4'b1100},
    {8'b01_00_01_00, 4'b1001, 4'b0011}
  };

  function automatic logic [3:0] expOe(logic [7:0] c, logic [3:0] o, bit afterRel);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [1:0] m;
      bit drv;
      m = c[2*i +: 2];
      drv = (m == 2'b00) || ((m == 2'b01) && !afterRel);
      r[i] = ~(drv & ~o[i]);
    end
    return r;
  endfunction

  function automatic logic [3:0] expIn(logic [7:0] c, logic [3:0] p);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (c[2*i +: 2] == 2'b00) ? 1'b0 : p[i];
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Launch: returns at the negedge of cycle 0 (first low cycle)
  task automatic launch(logic [7:0] c, logic [3:0] o, logic [3:0] p);
    cfg = c; outData = o; pinIn = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Full exchange checked from cycle 0 to cycle 63
  task automatic runChecked(logic [7:0] c, logic [3:0] o, logic [3:0] p);
    launch(c, o, p);
    chk("R2 strobe low at cycle 0", {7'd0, strobeN}, 8'd0);
    chk("R3 R6 drive at cycle 0", {4'd0, pinOeN}, {4'd0, expOe(c, o, 1'b0)});
    waitCyc(33);
    chk("R2 strobe low at cycle 33", {7'd0, strobeN}, 8'd0);
    waitCyc(1);
    chk("R2 strobe high at cycle 34", {7'd0, strobeN}, 8'd1);
    waitCyc(2);
    chk("R5 drive held at cycle 36", {4'd0, pinOeN}, {4'd0, expOe(c, o, 1'b0)});
    waitCyc(1);
    chk("R5 R4 drive after release cycle 37", {4'd0, pinOeN}, {4'd0, expOe(c, o, 1'b1)});
    waitCyc(24);
    chk("R8 done low at cycle 61", {7'd0, done}, 8'd0);
    waitCyc(1);
    chk("R8 done at cycle 62", {7'd0, done}, 8'd1);
    chk("R7 sampled input", {4'd0, inData}, {4'd0, expIn(c, p)});
    waitCyc(1);
    chk("R8 done low at cycle 63", {7'd0, done}, 8'd0);
    chk("R4 output drive kept after exchange", {4'd0, pinOeN}, {4'd0, expOe(c, o, 1'b1)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    waitCyc(3);
    chk("R1 strobe in reset", {7'd0, strobeN}, 8'd1);
    chk("R1 oe in reset", {4'd0, pinOeN}, 8'h0f);
    chk("R1 inData in reset", {4'd0, inData}, 8'd0);
    chk("R1 done in reset", {7'd0, done}, 8'd0);
    rstN = 1'b1;
    waitCyc(3);
    chk("R1 strobe after reset", {7'd0, strobeN}, 8'd1);
    chk("R1 oe after reset", {4'd0, pinOeN}, 8'h0f);

    for (int v = 0; v < 6; v++) begin
      runChecked(VEC[v][15:8], VEC[v][7:4], VEC[v][3:0]);
      waitCyc(4);
    end

    // R4: output pins hold while idle, change only at the next falling edge
    runChecked(8'b00_00_00_00, 4'b0011, 4'b0000);
    waitCyc(20);
    chk("R4 drive held while idle", {4'd0, pinOeN}, 8'h03);
    cfg = 8'b00_00_00_00; outData = 4'b1100; start = 1'b1;
    chk("R4 drive unchanged before launch edge", {4'd0, pinOeN}, 8'h03);
    @(negedge clk);
    start = 1'b0;
    chk("R4 new drive at cycle 0", {4'd0, pinOeN}, 8'h0c);

    // R9 R10: start with new cfg/outData during an exchange is ignored
    waitCyc(10);
    cfg = 8'b10_10_10_10; outData = 4'b0000; pinIn = 4'b1010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 drive unchanged by mid-exchange cfg", {4'd0, pinOeN}, 8'h0c);
    waitCyc(22);
    chk("R9 strobe still low at cycle 33", {7'd0, strobeN}, 8'd0);
    waitCyc(1);
    chk("R9 strobe high at cycle 34", {7'd0, strobeN}, 8'd1);
    waitCyc(28);
    chk("R8 R9 single done at cycle 62", {7'd0, done}, 8'd1);
    chk("R10 sample uses captured modes", {4'd0, inData}, 8'h00);
    waitCyc(1);
    chk("R9 no second exchange", {7'd0, strobeN}, 8'd1);
    waitCyc(40);
    chk("R9 still idle", {7'd0, strobeN}, 8'd1);
    chk("R8 no extra done", {7'd0, done}, 8'd0);

    // R11: start in the done cycle is accepted at once
    launch(8'b01_01_01_01, 4'b0000, 4'b1111);
    waitCyc(62);
    chk("R8 done before back-to-back", {7'd0, done}, 8'd1);
    cfg = 8'b00_00_00_00; outData = 4'b0110; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 strobe low right after done", {7'd0, strobeN}, 8'd0);
    chk("R11 new drive at cycle 0", {4'd0, pinOeN}, 8'h06);
    waitCyc(62);
    chk("R11 second exchange done", {7'd0, done}, 8'd1);
    chk("R7 output pins read 0", {4'd0, inData}, 8'h00);
    waitCyc(2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule